// File: doc/BRIEF.md
# Instruction fetch nibble sequencer

This controller feeds a small 4-bit execution unit from an external serial memory. It keeps a program counter and asks a separate serial read engine for one byte at that address through a start/busy/done handshake. It latches the returned byte and then issues the two 4-bit operations packed in that byte to the execution unit, one after the other. Each issue puts the operation on an opcode bus and raises a one-cycle start strobe.

The low half of the byte is issued first. The high half is issued only after the execution unit reports that the first operation is complete. The program counter steps by one only after the execution unit also finishes the high operation. It then wraps around silently at the top of its range, and the next fetch begins. A valid flag rises when the first instruction byte after reset has been captured.

The serial protocol and the arithmetic datapath are outside this block. All outputs are registered, and reset is synchronous and active high.

Top module: `nibble_fetch_seq`

## Requirements
- R1: While reset is high, at the first clock edge and afterwards, rd_start, op_start and valid are 0, op_code is 0 and rd_addr is 0.
- R2: rd_start is asserted only at a clock edge where rd_busy was sampled low while the controller waited to fetch. It lasts exactly one cycle. No new request is made until both nibbles of the current byte have completed.
- R3: While rd_start is high, rd_addr carries the current program counter. The first request after reset is for address 0.
- R4: At the edge where rd_done is sampled high, the byte on rd_data is captured. Bits [3:0] of that byte appear on op_code in the following cycle, with op_start high for exactly one cycle.
- R5: Bits [7:4] of the captured byte are issued with a one-cycle op_start only after ex_done has been sampled high in a cycle when op_start was low. An ex_done seen in the same cycle as an op_start pulse is ignored.
- R6: After ex_done is accepted for the high nibble, the program counter advances by exactly one. The next rd_start requests that address.
- R7: The program counter wraps from 0xFFF to 0x000 and continues fetching with no other indication.
- R8: valid is 0 from reset until the first byte is captured. It is 1 from the following cycle until the next reset.
- R9: op_code changes only in a cycle where op_start is high. Otherwise it holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_busy | input | 1 | Read engine is occupied |
| rd_done | input | 1 | Read engine finished; rd_data valid this cycle |
| rd_data | input | 8 | Byte returned by the read engine |
| rd_start | output | 1 | One-cycle byte read request |
| rd_addr | output | 12 | Byte address of the request (program counter) |
| ex_done | input | 1 | Execution unit finished the last issued operation |
| op_code | output | 4 | Operation presented to the execution unit |
| op_start | output | 1 | One-cycle issue strobe for op_code |
| valid | output | 1 | First instruction byte has been captured |

## Verification
The bench keeps the default widths: a 12-bit program counter and 4-bit operations, so each fetched byte is 8 bits. At these widths a run of a little over 4096 fetches crosses the 0xFFF to 0x000 boundary. That brings the wraparound, and the return to address 0 after a mid-run reset, within the cycle budget. Read latency, execution latency, idle busy windows and acknowledges that land on a strobe cycle are varied at random around that walk.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_WAIT  = 2'd1,
    ST_EX_LO = 2'd2,
    ST_EX_HI = 2'd3
  } nfs_state_t;

endpackage

// File: rtl/nfs_pc.sv
module nfs_pc #(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  output logic [PC_W-1:0] pc
);

  logic [PC_W-1:0] pc_q;

  // Plain modular increment: the top address rolls over to zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (inc) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  assign pc = pc_q;

endmodule

// File: rtl/nfs_ireg.sv
module nfs_ireg #(
  parameter int OP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_en,
  input  logic              issue_hi,
  input  logic [2*OP_W-1:0] rd_data,
  output logic [OP_W-1:0]   op_code
);

  localparam int NIBS   = 2;
  localparam int BYTE_W = NIBS * OP_W;

  logic [BYTE_W-1:0] instr_q;
  logic [OP_W-1:0]   in_nib  [NIBS];
  logic [OP_W-1:0]   reg_nib [NIBS];
  logic [OP_W-1:0]   op_q;

  for (genvar g = 0; g < NIBS; g++) begin : g_slice
    assign in_nib[g]  = rd_data[g*OP_W +: OP_W];
    assign reg_nib[g] = instr_q[g*OP_W +: OP_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q <= '0;
    end else if (latch_en) begin
      instr_q <= rd_data;
    end
  end

  // The low nibble goes straight from the returned byte;
  // the high nibble comes from the stored copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= '0;
    end else if (latch_en) begin
      op_q <= in_nib[0];
    end else if (issue_hi) begin
      op_q <= reg_nib[1];
    end
  end

  assign op_code = op_q;

endmodule

// File: rtl/nfs_ctrl.sv
module nfs_ctrl
  import nfs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_busy,
  input  logic rd_done,
  input  logic ex_done,
  output logic rd_start,
  output logic op_start,
  output logic valid,
  output logic latch_en,
  output logic issue_hi,
  output logic pc_inc
);

  nfs_state_t state_q, state_d;
  logic       rd_start_q, op_start_q, valid_q;
  logic       fetch_go, ex_ack;

  always_comb begin
    fetch_go = (state_q == ST_FETCH) && !rd_busy;
    latch_en = (state_q == ST_WAIT) && rd_done;
    // An acknowledge that coincides with the issue strobe belongs to
    // the previous operation and is not taken.
    ex_ack   = ex_done && !op_start_q;
    issue_hi = (state_q == ST_EX_LO) && ex_ack;
    pc_inc   = (state_q == ST_EX_HI) && ex_ack;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH: if (fetch_go) state_d = ST_WAIT;
      ST_WAIT:  if (latch_en) state_d = ST_EX_LO;
      ST_EX_LO: if (issue_hi) state_d = ST_EX_HI;
      ST_EX_HI: if (pc_inc)   state_d = ST_FETCH;
      default:                state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_FETCH;
      rd_start_q <= 1'b0;
      op_start_q <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      rd_start_q <= fetch_go;
      op_start_q <= latch_en || issue_hi;
      if (latch_en) valid_q <= 1'b1;
    end
  end

  assign rd_start = rd_start_q;
  assign op_start = op_start_q;
  assign valid    = valid_q;

endmodule

// File: rtl/nibble_fetch_seq.sv
module nibble_fetch_seq #(
  parameter int PC_W = 12,
  parameter int OP_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_busy,
  input  logic                rd_done,
  input  logic [2*OP_W-1:0]   rd_data,
  output logic                rd_start,
  output logic [PC_W-1:0]     rd_addr,
  input  logic                ex_done,
  output logic [OP_W-1:0]     op_code,
  output logic                op_start,
  output logic                valid
);

  logic latch_en, issue_hi, pc_inc;

  nfs_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rd_busy  (rd_busy),
    .rd_done  (rd_done),
    .ex_done  (ex_done),
    .rd_start (rd_start),
    .op_start (op_start),
    .valid    (valid),
    .latch_en (latch_en),
    .issue_hi (issue_hi),
    .pc_inc   (pc_inc)
  );

  nfs_ireg #(.OP_W(OP_W)) u_ireg (
    .clk      (clk),
    .rst      (rst),
    .latch_en (latch_en),
    .issue_hi (issue_hi),
    .rd_data  (rd_data),
    .op_code  (op_code)
  );

  nfs_pc #(.PC_W(PC_W)) u_pc (
    .clk (clk),
    .rst (rst),
    .inc (pc_inc),
    .pc  (rd_addr)
  );

endmodule

// File: rtl/nfs_checker.sv
module nfs_checker #(
  parameter int PC_W = 12,
  parameter int OP_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_busy,
  input logic            rd_start,
  input logic [PC_W-1:0] rd_addr,
  input logic            op_start,
  input logic [OP_W-1:0] op_code,
  input logic            valid
);

  logic [PC_W-1:0] prev_addr;
  logic [PC_W-1:0] step_addr;

  always_ff @(posedge clk) begin
    if (rst) prev_addr <= '0;
    else     prev_addr <= rd_addr;
  end

  assign step_addr = prev_addr + 1'b1;

  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    rd_start |-> $past(!rd_busy)); // R2

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> !rd_start); // R2

  AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !op_start); // R4

  AST_OPCODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_start |-> $stable(op_code)); // R9

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_addr != prev_addr) |-> (rd_addr == step_addr)); // R6

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (rst)
    $past(valid) |-> valid); // R8

endmodule

bind nibble_fetch_seq nfs_checker #(.PC_W(PC_W), .OP_W(OP_W)) u_nfs_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_busy  (rd_busy),
  .rd_start (rd_start),
  .rd_addr  (rd_addr),
  .op_start (op_start),
  .op_code  (op_code),
  .valid    (valid)
);

// File: tb/nibble_fetch_seq_bench.sv
module nibble_fetch_seq_bench;

  localparam int CLK_P = 10;
  localparam int PC_W  = 12;
  localparam int OP_W  = 4;
  localparam int PC_MASK = (1 << PC_W) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            rd_busy = 1'b0;
  logic            rd_done = 1'b0;
  logic [7:0]      rd_data = '0;
  logic            rd_start;
  logic [PC_W-1:0] rd_addr;
  logic            ex_done = 1'b0;
  logic [OP_W-1:0] op_code;
  logic            op_start;
  logic            valid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nibble_fetch_seq #(.PC_W(PC_W), .OP_W(OP_W)) u_nibble_fetch_seq (
    .clk(clk), .rst(rst), .rd_busy(rd_busy), .rd_done(rd_done),
    .rd_data(rd_data), .rd_start(rd_start), .rd_addr(rd_addr),
    .ex_done(ex_done), .op_code(op_code), .op_start(op_start), .valid(valid)
  );

  function automatic logic [7:0] mem_byte(input int a);
    return 8'((a * 29) ^ (a >> 5) ^ 8'h6C);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // model state
  int  eng_cnt, ex_cnt, hold, rst_cnt, bytes_done;
  int  exp_pc, phase;
  bit  ready_ok, prev_busy, prev_ex, prev_ops, prev_rs, seen_byte, wrap_seen, end_flag;
  logic [OP_W-1:0] last_op;

  always @(negedge clk) begin
    if (rst) begin
      rst_cnt++;
      if (rst_cnt >= 2) begin
        chk(rd_start == 1'b0, "R1 rd_start", rd_start, 0);
        chk(op_start == 1'b0, "R1 op_start", op_start, 0);
        chk(valid == 1'b0,    "R1/R8 valid", valid, 0);
        chk(op_code == '0,    "R1 op_code", op_code, 0);
        chk(rd_addr == '0,    "R1 rd_addr", rd_addr, 0);
      end
      eng_cnt = 0; ex_cnt = 0; hold = 6; exp_pc = 0; phase = 0; bytes_done = 0;
      ready_ok = 0; prev_busy = 1; prev_ex = 0; prev_ops = 0; prev_rs = 0;
      seen_byte = 0; last_op = '0;
      rd_busy = 1'b1; rd_done = 1'b0; ex_done = 1'b0;
    end else begin
      rst_cnt = 0;
      if (prev_ex && !prev_ops) ready_ok = 1;

      chk(valid == seen_byte, "R8 valid", valid, seen_byte);

      // read request side
      if (prev_rs && rd_start) chk(1'b0, "R2 request longer than one cycle", 1, 0);
      if (rd_start) begin
        chk(!prev_busy, "R2 request while busy", prev_busy, 0);
        if (phase == 3) begin
          chk(ready_ok, "R6 advance without acknowledge", ready_ok, 1);
          exp_pc = (exp_pc + 1) & PC_MASK;
          bytes_done++;
          if (exp_pc == 0) wrap_seen = 1;
          if (wrap_seen && exp_pc == 2) end_flag = 1;
        end else if (phase != 0) begin
          chk(1'b0, "R2 request before byte completed", phase, 3);
        end
        if (exp_pc == 0 && bytes_done > 0)
          chk(rd_addr == PC_W'(exp_pc), "R7 wrap address", rd_addr, exp_pc);
        else
          chk(rd_addr == PC_W'(exp_pc), "R3 request address", rd_addr, exp_pc);
        ready_ok = 0;
        phase = 1;
        eng_cnt = 1 + int'($urandom % 3);
        rd_done = 1'b0;
      end else if (eng_cnt > 0) begin
        eng_cnt--;
        if (eng_cnt == 0) begin
          rd_done = 1'b1;
          rd_data = mem_byte(exp_pc);
          seen_byte = 1;
        end else begin
          rd_done = 1'b0;
        end
      end else begin
        rd_done = 1'b0;
      end

      // execution side
      if (prev_ops && op_start) chk(1'b0, "R4 strobe longer than one cycle", 1, 0);
      if (op_start) begin
        if (phase == 1) begin
          chk(op_code == mem_byte(exp_pc)[3:0], "R4 low nibble", op_code, mem_byte(exp_pc)[3:0]);
          phase = 2;
        end else if (phase == 2) begin
          chk(ready_ok, "R5 high nibble without acknowledge", ready_ok, 1);
          chk(op_code == mem_byte(exp_pc)[7:4], "R5 high nibble", op_code, mem_byte(exp_pc)[7:4]);
          phase = 3;
          hold = int'($urandom % 3);
        end else begin
          chk(1'b0, "R4 unexpected strobe", phase, 1);
        end
        last_op = op_code;
        ready_ok = 0;
        ex_cnt = 1 + int'($urandom % 3);
        // sometimes leave the acknowledge up during the strobe cycle
        ex_done = (($urandom % 4) == 0);
      end else begin
        chk(op_code == last_op, "R9 op_code held", op_code, last_op);
        if (ex_cnt > 0) begin
          ex_done = 1'b0;
          ex_cnt--;
        end else begin
          ex_done = 1'b1;
        end
      end

      if (hold > 0) hold--;
      rd_busy = (eng_cnt > 0) || (hold > 0);
      prev_busy = rd_busy;
      prev_ex   = ex_done;
      prev_ops  = op_start;
      prev_rs   = rd_start;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #(CLK_P/4) rst = 1'b0;
    wait (bytes_done == 20);
    @(posedge clk);
    #(CLK_P/4) rst = 1'b1;
    repeat (4) @(posedge clk);
    #(CLK_P/4) rst = 1'b0;
    wait (end_flag);
    repeat (4) @(posedge clk);
    chk(wrap_seen, "R7 wrap reached", wrap_seen, 1);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

endmodule